// File: doc/BRIEF.md
# Video Timing Controller CPU Register Port

This block is the processor-facing side of a character-based video timing controller. The processor reaches it through two byte locations, chosen by a single register-select line. A write with the select line low picks which internal register is addressed next. A write with the select line high places a byte into that register. Each stored register keeps only the bits that the timing logic uses. Reads return either a status byte or the readback value of the addressed register. Most registers cannot be read back.

The masked register contents go out on one flat bus to the raster timing logic. The timing logic returns a vertical-retrace flag, which appears in the status byte. Writing the cursor-start register also gives a two-bit cursor mode. When that mode changes, the blink state is set to on and the blink counter is reloaded, so the cursor logic restarts its blink from a known point.

Top module: `vtc_cpu_regs`

## Requirements
- R1: On a rising clock edge with chipSel=1, wrEn=1 and regSel=0, the address register takes wrData[4:0]. Bits 7:5 are discarded.
- R2: On a rising clock edge with chipSel=1, wrEn=1, regSel=1 and address below 16, the addressed register takes wrData ANDed with its mask. The mask is 0x7F for registers 4, 6, 7, 10 and 11, 0x1F for registers 5 and 9, 0x3F for registers 12 and 14, and 0xFF for registers 0–3, 8, 13 and 15. Register k occupies regBank[8k+7:8k].
- R3: A write with regSel=1 to address 16 through 31 (16 and 17 are read-only) leaves every register, the address register and the cursor outputs unchanged.
- R4: With chipSel=1, rdEn=1 and regSel=0, rdData is 0x20 while vRetrace=1 and 0x00 while vRetrace=0.
- R5: With chipSel=1, rdEn=1 and regSel=1, rdData is the stored byte when the address is 14 or 15, 0xFF when it is 16 or 17, and 0x00 for any other address.
- R6: A write to register 10 computes mode = wrData[6:5] XOR 2'b01. If the mode differs from cursorMode, then at that edge cursorMode takes the mode, blinkOn becomes 1 and blinkCnt becomes 16. Otherwise the cursor outputs are unchanged.
- R7: When chipSel=0 or wrEn=0, no stored state changes at the clock edge.
- R8: When chipSel=0 or rdEn=0, rdData is 0x00.
- R9: After reset (rst_n=0), all registers, the address register, cursorMode, blinkOn and blinkCnt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chipSel | input | 1 | Chip select |
| regSel | input | 1 | Register select: 0 selects address/status, 1 selects data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data from the processor |
| rdData | output | 8 | Read data to the processor (combinational) |
| vRetrace | input | 1 | Vertical-retrace flag from the timing logic |
| regBank | output | 128 | Masked contents of registers 0–15, register k in bits 8k+7:8k |
| cursorMode | output | 2 | Current cursor mode |
| blinkOn | output | 1 | Cursor blink state |
| blinkCnt | output | 5 | Blink counter load value |

## Verification
The hardest case to reach is a cursor-start write whose mode equals the current mode. The mode only changes through this write, so the stimulus must first move it away from the reset value and then repeat the same upper bits. Directed writes set modes 1, then 1 again, then 0. The random phase aims about a quarter of its data writes at register 10 to keep revisiting both branches. Read-only and unmapped addresses are reached by addressing writes with random upper bits, so their discarded bits are also covered.

// File: rtl/vtc_regs_pkg.sv
package vtc_regs_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 5;
  localparam int NUM_STORED  = 16;
  localparam int BLINK_W     = 5;
  localparam int BLINK_LOAD  = 16;
  localparam int IDX_CSTART  = 10;
  localparam int IDX_CPOS_HI = 14;
  localparam int IDX_CPOS_LO = 15;
  localparam int IDX_PEN_HI  = 16;
  localparam int IDX_PEN_LO  = 17;

  typedef struct packed {
    logic addrWr;
    logic regWr;
    logic statusRd;
    logic regRd;
  } strobes_t;

  function automatic logic [DATA_W-1:0] regMask(input int idx);
    case (idx)
      4, 6, 7, 10, 11: regMask = 8'h7F;
      5, 9:            regMask = 8'h1F;
      12, 14:          regMask = 8'h3F;
      default:         regMask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/vtc_regs_ctrl.sv
module vtc_regs_ctrl
  import vtc_regs_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W,
  parameter int STORED    = NUM_STORED
) (
  input  logic                 chipSel,
  input  logic                 regSel,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_BITS-1:0] addrQ,
  output strobes_t             strobes
);
  logic wrCycle;
  logic rdCycle;
  logic addrMapped;

  assign wrCycle    = chipSel & wrEn;
  assign rdCycle    = chipSel & rdEn;
  assign addrMapped = (int'(addrQ) < STORED);

  always_comb begin
    strobes          = '0;
    strobes.addrWr   = wrCycle & ~regSel;
    strobes.regWr    = wrCycle & regSel & addrMapped;
    strobes.statusRd = rdCycle & ~regSel;
    strobes.regRd    = rdCycle & regSel;
  end
endmodule

// File: rtl/vtc_regs_data.sv
module vtc_regs_data
  import vtc_regs_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W,
  parameter int STORED    = NUM_STORED,
  localparam int BANK_W   = STORED * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobes_t             strobes,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 vRetrace,
  output logic [ADDR_BITS-1:0] addrQ,
  output logic [DATA_W-1:0]    rdData,
  output logic [BANK_W-1:0]    regBank,
  output logic [1:0]           cursorMode,
  output logic                 blinkOn,
  output logic [BLINK_W-1:0]   blinkCnt
);
  logic [DATA_W-1:0] bankQ [STORED];
  logic [1:0]        newMode;
  logic              cstartWr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addrQ <= '0;
    else if (strobes.addrWr) addrQ <= wrData[ADDR_BITS-1:0];
  end

  for (genvar g = 0; g < STORED; g++) begin : gReg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bankQ[g] <= '0;
      else if (strobes.regWr && int'(addrQ) == g) bankQ[g] <= wrData & regMask(g);
    end
    assign regBank[g*DATA_W +: DATA_W] = bankQ[g];
  end

  assign newMode  = wrData[6:5] ^ 2'b01;
  assign cstartWr = strobes.regWr && int'(addrQ) == IDX_CSTART;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cursorMode <= '0;
      blinkOn    <= 1'b0;
      blinkCnt   <= '0;
    end else if (cstartWr && newMode != cursorMode) begin
      cursorMode <= newMode;
      blinkOn    <= 1'b1;
      blinkCnt   <= BLINK_W'(BLINK_LOAD);
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.statusRd) begin
      rdData[5] = vRetrace;
    end else if (strobes.regRd) begin
      case (int'(addrQ))
        IDX_CPOS_HI, IDX_CPOS_LO: rdData = bankQ[addrQ[$clog2(STORED)-1:0]];
        IDX_PEN_HI, IDX_PEN_LO:   rdData = '1;
        default:                  rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/vtc_cpu_regs.sv
module vtc_cpu_regs
  import vtc_regs_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          chipSel,
  input  logic                          regSel,
  input  logic                          wrEn,
  input  logic                          rdEn,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             rdData,
  input  logic                          vRetrace,
  output logic [NUM_STORED*DATA_W-1:0]  regBank,
  output logic [1:0]                    cursorMode,
  output logic                          blinkOn,
  output logic [BLINK_W-1:0]            blinkCnt
);
  strobes_t          strobes;
  logic [ADDR_W-1:0] addrQ;

  vtc_regs_ctrl #(.ADDR_BITS(ADDR_W), .STORED(NUM_STORED)) u_ctrl (
    .chipSel (chipSel),
    .regSel  (regSel),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addrQ   (addrQ),
    .strobes (strobes)
  );

  vtc_regs_data #(.ADDR_BITS(ADDR_W), .STORED(NUM_STORED)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .wrData     (wrData),
    .vRetrace   (vRetrace),
    .addrQ      (addrQ),
    .rdData     (rdData),
    .regBank    (regBank),
    .cursorMode (cursorMode),
    .blinkOn    (blinkOn),
    .blinkCnt   (blinkCnt)
  );
endmodule

// File: rtl/vtc_regs_chk.sv
module vtc_regs_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         chipSel,
  input logic         regSel,
  input logic         wrEn,
  input logic         rdEn,
  input logic [7:0]   wrData,
  input logic [7:0]   rdData,
  input logic         vRetrace,
  input logic [4:0]   addrQ,
  input logic [127:0] regBank,
  input logic [1:0]   cursorMode,
  input logic         blinkOn,
  input logic [4:0]   blinkCnt
);
  // R1
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chipSel && wrEn && !regSel) |=> (addrQ == $past(wrData[4:0])));

  // R2
  width_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regBank[39] == 1'b0) && (regBank[103:102] == 2'b00) && (regBank[47:45] == 3'b000));

  // R3
  unmapped_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chipSel && wrEn && regSel && addrQ >= 5'd16) |=> ($stable(regBank) && $stable(cursorMode) && $stable(blinkCnt)));

  // R4
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chipSel && rdEn && !regSel) |-> (rdData == {2'b00, vRetrace, 5'b00000}));

  // R5
  pen_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chipSel && rdEn && regSel && (addrQ == 5'd16 || addrQ == 5'd17)) |-> (rdData == 8'hFF));

  // R6
  cursor_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chipSel && wrEn && regSel && addrQ == 5'd10 && ((wrData[6:5] ^ 2'b01) != cursorMode))
    |=> (blinkOn && blinkCnt == 5'd16 && cursorMode == ($past(wrData[6:5]) ^ 2'b01)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(chipSel && wrEn) |=> ($stable(regBank) && $stable(addrQ) && $stable(cursorMode) && $stable(blinkOn)));

  // R8
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(chipSel && rdEn) |-> (rdData == 8'h00));
endmodule

bind vtc_cpu_regs vtc_regs_chk u_chk (.*);

// File: tb/sim_vtc_cpu_regs.sv
module sim_vtc_cpu_regs;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         chipSel = 1'b0, regSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]   wrData = '0;
  logic [7:0]   rdData;
  logic         vRetrace = 1'b0;
  logic [127:0] regBank;
  logic [1:0]   cursorMode;
  logic         blinkOn;
  logic [4:0]   blinkCnt;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] mBank [16];
  logic [4:0] mAddr;
  logic [1:0] mMode;
  logic       mBlink;
  logic [4:0] mCnt;

  always #10 clk = ~clk;

  vtc_cpu_regs u0 (
    .clk(clk), .rst_n(rst_n), .chipSel(chipSel), .regSel(regSel), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .vRetrace(vRetrace),
    .regBank(regBank), .cursorMode(cursorMode), .blinkOn(blinkOn), .blinkCnt(blinkCnt)
  );

  function automatic logic [7:0] maskOf(input int k);
    if (k == 4 || k == 6 || k == 7 || k == 10 || k == 11) return 8'h7F;
    if (k == 5 || k == 9) return 8'h1F;
    if (k == 12 || k == 14) return 8'h3F;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] expRead(input logic rs, input logic vr);
    if (!rs) return {2'b00, vr, 5'b00000};
    if (mAddr == 5'd14 || mAddr == 5'd15) return mBank[mAddr[3:0]];
    if (mAddr == 5'd16 || mAddr == 5'd17) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [127:0] expBank();
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[k*8 +: 8] = mBank[k];
    return v;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < 16; k++) mBank[k] = '0;
    mAddr = '0; mMode = '0; mBlink = 1'b0; mCnt = '0;
  endtask

  task automatic doWrite(input logic cs, input logic we, input logic rs, input logic [7:0] d);
    logic [1:0] nm;
    @(negedge clk);
    chipSel = cs; wrEn = we; regSel = rs; wrData = d;
    @(negedge clk);
    chipSel = 1'b0; wrEn = 1'b0;
    if (cs && we) begin
      if (!rs) mAddr = d[4:0];
      else if (mAddr < 5'd16) begin
        mBank[mAddr[3:0]] = d & maskOf(int'(mAddr));
        if (mAddr == 5'd10) begin
          nm = d[6:5] ^ 2'b01;
          if (nm != mMode) begin mMode = nm; mBlink = 1'b1; mCnt = 5'd16; end
        end
      end
    end
    #1;
  endtask

  task automatic checkState(input string req);
    check(req, regBank, expBank());
    check(req, {cursorMode, blinkOn, blinkCnt}, {mMode, mBlink, mCnt});
  endtask

  task automatic doRead(input logic cs, input logic re, input logic rs, input string req);
    @(negedge clk);
    chipSel = cs; rdEn = re; regSel = rs;
    #2;
    check(req, rdData, (cs && re) ? expRead(rs, vRetrace) : 8'h00);
    chipSel = 1'b0; rdEn = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checkState("R9 reset");
    doRead(1, 1, 1, "R9 reset addr readback");

    // R1: upper bits dropped, 0xE4 -> address 4
    doWrite(1, 1, 0, 8'hE4);
    doWrite(1, 1, 1, 8'hFF);
    checkState("R1 R2 masked R4 write");
    // R2 display start high 6 bits
    doWrite(1, 1, 0, 8'd12);
    doWrite(1, 1, 1, 8'hFF);
    checkState("R2 reg12 mask");
    doRead(1, 1, 1, "R5 write-only reg reads zero");
    // R5 cursor position readback
    doWrite(1, 1, 0, 8'd14);
    doWrite(1, 1, 1, 8'hFF);
    doRead(1, 1, 1, "R5 reg14 readback");
    doWrite(1, 1, 0, 8'd15);
    doWrite(1, 1, 1, 8'hA5);
    doRead(1, 1, 1, "R5 reg15 readback");
    doWrite(1, 1, 0, 8'd17);
    doRead(1, 1, 1, "R5 pen reads FF");
    // R3 writes to read-only / unmapped addresses
    doWrite(1, 1, 1, 8'h5A);
    checkState("R3 write to reg17 ignored");
    doWrite(1, 1, 0, 8'd31);
    doWrite(1, 1, 1, 8'hC3);
    checkState("R3 write to reg31 ignored");
    // R4 status
    vRetrace = 1'b1;
    doRead(1, 1, 0, "R4 status retrace");
    vRetrace = 1'b0;
    doRead(1, 1, 0, "R4 status no retrace");
    // R7 no select / no strobe
    doWrite(0, 1, 0, 8'd3);
    doWrite(1, 0, 1, 8'h77);
    checkState("R7 idle write");
    doRead(1, 1, 1, "R7 address unchanged");
    // R8
    doRead(0, 1, 0, "R8 no chip select");
    doRead(1, 0, 1, "R8 no read strobe");
    // R6 cursor mode
    doWrite(1, 1, 0, 8'd10);
    doWrite(1, 1, 1, 8'h00);
    checkState("R6 mode change to 1");
    doWrite(1, 1, 1, 8'h1F);
    checkState("R6 same mode no reload");
    doWrite(1, 1, 1, 8'h20);
    checkState("R6 mode change to 0");
    doWrite(1, 1, 1, 8'h60);
    checkState("R6 mode change to 2");

    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0, 1: doWrite(1, 1, 0, 8'($urandom));
        2:    begin doWrite(1, 1, 0, 8'd10); doWrite(1, 1, 1, 8'($urandom)); end
        3, 4: doWrite(1, 1, 1, 8'($urandom));
        5:    doWrite(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
        6:    begin vRetrace = 1'($urandom); doRead(1, 1, 0, "R4 random status"); end
        default: doRead(1'($urandom), 1'($urandom), 1, "R5 R8 random read");
      endcase
      checkState("R2 R3 R6 R7 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule